// File: doc/BRIEF.md
# Phase-Step Request Sequencer

This block sits in user logic beside a clock generator that lets the phase of its output clocks be moved at run time. A client asks for a phase move with a 4-bit output mask, a direction and a step count. The sequencer stops the clocks of the chosen outputs through their gating enables, lets the gating cells settle, and then presents the select and direction lines. It issues one rotate pulse for each step and then turns the clocks back on. A second request input makes the generator reload its initial phases, wrapped in the same stop/settle/restart sequence.

No work is accepted until the generator has been through a power-down cycle since this block left reset, has been released and reports lock. Requests that name an output driven through a post-divider (set by the `DIVIDED_OUTS` parameter) are refused with a one-cycle reject pulse. The states are ST_IDLE, ST_STOP, ST_WAIT_STOP, ST_SETUP, ST_PULSE_HI, ST_PULSE_LO, ST_START and ST_DONE. The transitions are:
- IDLE to STOP on an accepted restore or a phase request with a non-zero count and mask.
- IDLE to DONE on a phase request whose count or mask is zero.
- STOP to WAIT_STOP after one cycle.
- WAIT_STOP to SETUP after `SETTLE_CYC` cycles.
- SETUP to PULSE_HI after one cycle.
- PULSE_HI to PULSE_LO after `ROT_HI_CYC` cycles.
- PULSE_LO back to PULSE_HI while steps remain, otherwise to START, after `ROT_LO_CYC` cycles.
- START to DONE.
- DONE to IDLE.

Top module: `phase_step_seq`

## Requirements
- R1: A request is accepted only when three conditions hold: `gen_pwrdn_n` has been seen low since `rst_n` was released, `gen_pwrdn_n` is now high, and `gen_lock` is high. Requests made at any other time are dropped, and `busy` stays low.
- R2: A phase request whose mask overlaps `DIVIDED_OUTS` raises `rejected` for exactly the one cycle after it is sampled. No clock enable drops and `busy` stays low.
- R3: In the cycle after an accepted phase request with a non-zero count and mask, `clk_en[i]` goes low for every bit i set in the mask (bit i is output i). The other enables stay high. The stopped enables remain low until the last low phase ends.
- R4: For `SETTLE_CYC` (default 4) cycles after the stop cycle, `ph_sel` is zero and `ph_rotate` is low. Then `ph_sel` carries the mask for one setup cycle before the first rotate rising edge.
- R5: `ph_rotate` shows exactly as many rising edges as the requested step count (3 bits, 1 to 7). Each pulse is high for `ROT_HI_CYC` (2) cycles and then low for `ROT_LO_CYC` (2) cycles.
- R6: The mask on `ph_sel` and the direction on `ph_dir` (1 = forward, 0 = backward) stay constant from the setup cycle to the end of the last low phase. `ph_sel` is zero at all other times.
- R7: In the cycle after the last low phase, all enables are high again. `done` follows one cycle later.
- R8: A phase request with a step count of 0 or an empty mask raises `done` in the cycle after acceptance. It stops no clock and issues no rotate pulse.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. `done` lasts one cycle. Requests and restores that arrive while `busy` is high are ignored. After reset, all outputs are idle: enables high, `ph_sel` zero, `ph_rotate` low, `ph_reload_n` high, and `busy`, `done` and `rejected` low.
- R10: A restore request stops all four enables. After the settle time and one setup cycle, it drives `ph_reload_n` low for `ROT_HI_CYC` cycles and high for `ROT_LO_CYC` cycles. It then restarts the clocks and raises `done`, with `ph_rotate` held low throughout. A restore wins over a phase request sampled in the same cycle.
- R11: `ph_rotate` is high only while every selected output has its enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| gen_pwrdn_n | input | 1 | Observed power-down line of the clock generator (low = held in power-down) |
| gen_lock | input | 1 | Generator lock indication |
| req_valid | input | 1 | Phase-move request strobe |
| req_mask | input | 4 | Outputs to move, bit i = output i |
| req_dir | input | 1 | 1 = forward, 0 = backward |
| req_steps | input | 3 | Number of one-eighth phase steps |
| restore_req | input | 1 | Request to reload the initial phases |
| clk_en | output | 4 | Gating enables of the four output clocks (1 = running) |
| ph_sel | output | 4 | Output select lines of the phase port |
| ph_dir | output | 1 | Direction line of the phase port |
| ph_rotate | output | 1 | Rotate line; each rising edge moves one step |
| ph_reload_n | output | 1 | Active-low initial-phase reload line |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | One-cycle refusal pulse for a post-divided target |

## Verification
The sequence is exercised with single-output and multi-output masks, with both directions, and with every step count from 0 to 7. Comparing each cycle against a trace predicted from the count separates off-by-one errors in the settle window, the pulse widths and the loop-back decision. Empty masks and zero counts show whether the short path skips the clock stop. Masks touching a post-divided output show whether refusal wins over acceptance. Stray requests injected mid-sequence, and a restore raised together with a phase request, expose ignored-while-busy and priority faults. Generator sequences with no power-down, with lock low, and with lock lost later check the admission gate.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_WAIT_STOP,
        ST_SETUP,
        ST_PULSE_HI,
        ST_PULSE_LO,
        ST_START,
        ST_DONE
    } pss_state_e;
endpackage

// File: rtl/pss_ready_tracker.sv
module pss_ready_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_pwrdn_n,
    input  logic gen_lock,
    output logic ready
);
    logic seen_pwrdn_q;

    // Remember that the generator has been through power-down since our reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_pwrdn_q <= 1'b0;
        else if (!gen_pwrdn_n)
            seen_pwrdn_q <= 1'b1;
    end

    assign ready = seen_pwrdn_q && gen_pwrdn_n && gen_lock;
endmodule

// File: rtl/pss_cycle_timer.sv
module pss_cycle_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (count != CNT_MAX)
            count <= count + 1'b1;
    end

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == CNT_MAX) |=> (count == CNT_MAX)); // R5
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq
    import pss_pkg::*;
#(
    parameter int                N_OUT        = 4,
    parameter int                STEP_W       = 3,
    parameter int                SETTLE_CYC   = 4,
    parameter int                ROT_HI_CYC   = 2,
    parameter int                ROT_LO_CYC   = 2,
    parameter logic [N_OUT-1:0]  DIVIDED_OUTS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_pwrdn_n,
    input  logic              gen_lock,
    input  logic              req_valid,
    input  logic [N_OUT-1:0]  req_mask,
    input  logic              req_dir,
    input  logic [STEP_W-1:0] req_steps,
    input  logic              restore_req,
    output logic [N_OUT-1:0]  clk_en,
    output logic [N_OUT-1:0]  ph_sel,
    output logic              ph_dir,
    output logic              ph_rotate,
    output logic              ph_reload_n,
    output logic              busy,
    output logic              done,
    output logic              rejected
);
    localparam int MAX_A   = (SETTLE_CYC > ROT_HI_CYC) ? SETTLE_CYC : ROT_HI_CYC;
    localparam int MAX_WIN = (MAX_A > ROT_LO_CYC) ? MAX_A : ROT_LO_CYC;
    localparam int TMR_W   = $clog2(MAX_WIN + 1);
    localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] HI_LAST     = TMR_W'(ROT_HI_CYC - 1);
    localparam logic [TMR_W-1:0] LO_LAST     = TMR_W'(ROT_LO_CYC - 1);
    localparam logic [STEP_W-1:0] ONE_STEP   = STEP_W'(1);

    pss_state_e        state_q, state_d;
    logic [N_OUT-1:0]  mask_q, mask_d;
    logic              dir_q, dir_d;
    logic [STEP_W-1:0] steps_q, steps_d;
    logic              restore_q, restore_d;
    logic              rej_q, rej_d;
    logic              ready;
    logic [TMR_W-1:0]  tcount;
    logic              timer_clr;

    logic idle_ready, take_restore, req_clean, take_req, bad_req, req_empty;
    logic stop_phase, sel_phase;

    pss_ready_tracker u_ready (
        .clk         (clk),
        .rst_n       (rst_n),
        .gen_pwrdn_n (gen_pwrdn_n),
        .gen_lock    (gen_lock),
        .ready       (ready)
    );

    pss_cycle_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .count (tcount)
    );

    // Request admission.
    assign idle_ready   = (state_q == ST_IDLE) && ready;
    assign take_restore = idle_ready && restore_req;
    assign req_clean    = (req_mask & DIVIDED_OUTS) == '0;
    assign take_req     = idle_ready && !restore_req && req_valid && req_clean;
    assign bad_req      = idle_ready && !restore_req && req_valid && !req_clean;
    assign req_empty    = (req_steps == '0) || (req_mask == '0);

    // Next-state and data capture.
    always_comb begin
        state_d   = state_q;
        mask_d    = mask_q;
        dir_d     = dir_q;
        steps_d   = steps_q;
        restore_d = restore_q;
        rej_d     = bad_req;
        unique case (state_q)
            ST_IDLE: begin
                if (take_restore) begin
                    state_d   = ST_STOP;
                    mask_d    = '1;
                    steps_d   = ONE_STEP;
                    restore_d = 1'b1;
                end else if (take_req) begin
                    state_d   = req_empty ? ST_DONE : ST_STOP;
                    mask_d    = req_mask;
                    dir_d     = req_dir;
                    steps_d   = req_steps;
                    restore_d = 1'b0;
                end
            end
            ST_STOP:      state_d = ST_WAIT_STOP;
            ST_WAIT_STOP: if (tcount == SETTLE_LAST) state_d = ST_SETUP;
            ST_SETUP:     state_d = ST_PULSE_HI;
            ST_PULSE_HI:  if (tcount == HI_LAST) state_d = ST_PULSE_LO;
            ST_PULSE_LO: begin
                if (tcount == LO_LAST) begin
                    steps_d = steps_q - ONE_STEP;
                    state_d = (steps_q > ONE_STEP) ? ST_PULSE_HI : ST_START;
                end
            end
            ST_START:     state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign timer_clr = (state_d != state_q);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mask_q    <= '0;
            dir_q     <= 1'b0;
            steps_q   <= '0;
            restore_q <= 1'b0;
            rej_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            mask_q    <= mask_d;
            dir_q     <= dir_d;
            steps_q   <= steps_d;
            restore_q <= restore_d;
            rej_q     <= rej_d;
        end
    end

    // Output decode.
    always_comb begin
        stop_phase  = 1'b0;
        sel_phase   = 1'b0;
        ph_rotate   = 1'b0;
        ph_reload_n = 1'b1;
        unique case (state_q)
            ST_STOP, ST_WAIT_STOP: stop_phase = 1'b1;
            ST_SETUP, ST_PULSE_LO: begin
                stop_phase = 1'b1;
                sel_phase  = 1'b1;
            end
            ST_PULSE_HI: begin
                stop_phase  = 1'b1;
                sel_phase   = 1'b1;
                ph_rotate   = !restore_q;
                ph_reload_n = !restore_q;
            end
            default: ;
        endcase
    end

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
        assign clk_en[gi] = !(stop_phase && mask_q[gi]);
        assign ph_sel[gi] = sel_phase && !restore_q && mask_q[gi];
    end

    assign ph_dir   = dir_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign rejected = rej_q;

    initial begin
        AST_PARAMS_VALID: assert (SETTLE_CYC >= 1 && ROT_HI_CYC >= 1 && ROT_LO_CYC >= 1); // R4
    end

    AST_UNREADY_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !ready) |=> !busy); // R1
    AST_REJECT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> (!busy && clk_en == '1)); // R2
    AST_ROTATE_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ph_rotate |-> (ph_sel != '0 && (clk_en & ph_sel) == '0)); // R11
    AST_RELOAD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_reload_n |-> (clk_en == '0 && !ph_rotate)); // R10
    AST_ROTATE_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_rotate) |=> ph_rotate); // R5
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_sel != '0 && $past(ph_sel) != '0) |-> ($stable(ph_sel) && $stable(ph_dir))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_RESTART_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (clk_en == '1 && busy)); // R7
endmodule

// File: tb/phase_step_seq_tb.sv
module phase_step_seq_tb;
    localparam int S = 4;
    localparam logic [3:0] DIV = 4'b1000;

    logic       clk = 1'b0;
    logic       rst_n, gen_pwrdn_n, gen_lock;
    logic       req_valid, req_dir, restore_req;
    logic [3:0] req_mask;
    logic [2:0] req_steps;
    logic [3:0] clk_en, ph_sel;
    logic       ph_dir, ph_rotate, ph_reload_n, busy, done, rejected;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    phase_step_seq #(.SETTLE_CYC(S), .DIVIDED_OUTS(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .gen_pwrdn_n(gen_pwrdn_n), .gen_lock(gen_lock),
        .req_valid(req_valid), .req_mask(req_mask), .req_dir(req_dir),
        .req_steps(req_steps), .restore_req(restore_req),
        .clk_en(clk_en), .ph_sel(ph_sel), .ph_dir(ph_dir), .ph_rotate(ph_rotate),
        .ph_reload_n(ph_reload_n), .busy(busy), .done(done), .rejected(rejected)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic int seq_len(input int s);
        return (s == 0) ? 3 : S + 6 + 4 * s;
    endfunction

    // Issue a phase request at a negedge and compare each following cycle.
    task automatic run_req(input logic [3:0] m, input logic d, input int s, input bit poke);
        int eff = (m == 4'd0) ? 0 : s;
        int last = seq_len(eff);
        int bad_stop = 0, bad_pre = 0, bad_rot = 0, bad_sel = 0, bad_bd = 0, bad_end = 0;
        int rises = 0;
        logic prev_rot = 1'b0;
        req_valid = 1'b1; req_mask = m; req_dir = d; req_steps = s[2:0];
        for (int t = 1; t <= last; t++) begin
            logic [3:0] e_en, e_sel;
            logic e_rot, e_busy, e_done;
            @(negedge clk);
            if (eff == 0) begin
                e_en = 4'hF; e_sel = 4'h0; e_rot = 1'b0;
                e_busy = (t == 1); e_done = (t == 1);
            end else begin
                e_en   = (t <= S + 2 + 4 * eff) ? ~m : 4'hF;
                e_sel  = (t >= S + 2 && t <= S + 2 + 4 * eff) ? m : 4'h0;
                e_rot  = (t >= S + 3 && t <= S + 2 + 4 * eff) && (((t - (S + 3)) % 4) < 2);
                e_busy = (t <= S + 4 + 4 * eff);
                e_done = (t == S + 4 + 4 * eff);
            end
            if (t <= S + 2 && (ph_sel !== e_sel || ph_rotate !== 1'b0)) bad_pre++;
            if (t <= S + 2 + 4 * eff && clk_en !== e_en) bad_stop++;
            if (t > S + 2 + 4 * eff && clk_en !== e_en) bad_end++;
            if (ph_rotate !== e_rot) bad_rot++;
            if (ph_sel !== e_sel || (e_sel != 4'h0 && ph_dir !== d)) bad_sel++;
            if (busy !== e_busy || done !== e_done || ph_reload_n !== 1'b1) bad_bd++;
            if (ph_rotate === 1'b1 && prev_rot === 1'b0) rises++;
            prev_rot = ph_rotate;
            if (poke && t == 3) begin
                req_valid = 1'b1; req_mask = 4'b0001; req_steps = 3'd5; restore_req = 1'b1;
            end else begin
                req_valid = 1'b0; restore_req = 1'b0;
            end
        end
        if (eff == 0) begin
            chk(bad_bd == 0 && bad_stop == 0 && rises == 0, "R8", "zero-step trace mismatches",
                bad_bd + bad_stop + rises, 0);
        end else begin
            chk(bad_stop == 0, "R3", "stop-window enable mismatches", bad_stop, 0);
            chk(bad_pre == 0, "R4", "settle/setup mismatches", bad_pre, 0);
            chk(bad_rot == 0 && rises == eff, "R5", "rotate rising edges", rises, eff);
            chk(bad_sel == 0, "R6", "select/direction mismatches", bad_sel, 0);
            chk(bad_end == 0, "R7", "restart enable mismatches", bad_end, 0);
            chk(bad_bd == 0, "R9", "busy/done mismatches", bad_bd, 0);
        end
    endtask

    task automatic run_reject(input logic [3:0] m, input int s);
        req_valid = 1'b1; req_mask = m; req_dir = 1'b1; req_steps = s[2:0];
        @(negedge clk);
        chk(rejected === 1'b1 && busy === 1'b0 && clk_en === 4'hF, "R2",
            "reject pulse first cycle", {rejected, busy}, 2);
        req_valid = 1'b0;
        @(negedge clk);
        chk(rejected === 1'b0 && busy === 1'b0 && clk_en === 4'hF, "R2",
            "reject pulse second cycle", {rejected, busy}, 0);
    endtask

    task automatic run_restore();
        int bad = 0;
        restore_req = 1'b1; req_valid = 1'b1; req_mask = 4'b0001; req_steps = 3'd3;
        for (int t = 1; t <= S + 10; t++) begin
            logic [3:0] e_en;
            logic e_rl;
            @(negedge clk);
            e_en = (t <= S + 6) ? 4'h0 : 4'hF;
            e_rl = !(t == S + 3 || t == S + 4);
            if (clk_en !== e_en || ph_reload_n !== e_rl || ph_rotate !== 1'b0 ||
                ph_sel !== 4'h0 || busy !== (t <= S + 8) || done !== (t == S + 8)) bad++;
            restore_req = 1'b0; req_valid = 1'b0;
        end
        chk(bad == 0, "R10", "restore trace mismatches", bad, 0);
    endtask

    task automatic expect_idle(input string req, input int cycles);
        int bad = 0;
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk);
            if (busy !== 1'b0 || clk_en !== 4'hF || ph_rotate !== 1'b0) bad++;
            req_valid = 1'b0;
        end
        chk(bad == 0, req, "request not held off", bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst_n = 1'b0; gen_pwrdn_n = 1'b1; gen_lock = 1'b1;
        req_valid = 1'b0; req_mask = 4'h0; req_dir = 1'b0; req_steps = 3'd0;
        restore_req = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_en === 4'hF && ph_sel === 4'h0 && ph_rotate === 1'b0 && ph_reload_n === 1'b1 &&
            busy === 1'b0 && done === 1'b0 && rejected === 1'b0, "R9", "reset state",
            {clk_en, ph_sel}, 8'hF0);

        // R1: generator never power-cycled since reset.
        req_valid = 1'b1; req_mask = 4'b0001; req_steps = 3'd1;
        expect_idle("R1", 3);
        gen_pwrdn_n = 1'b0; gen_lock = 1'b0;
        repeat (3) @(negedge clk);
        gen_pwrdn_n = 1'b1;
        @(negedge clk);
        // R1: released but not locked.
        req_valid = 1'b1;
        expect_idle("R1", 3);
        gen_lock = 1'b1;
        @(negedge clk);

        run_req(4'b0001, 1'b1, 1, 1'b0);
        run_req(4'b0111, 1'b0, 7, 1'b1);
        run_req(4'b0010, 1'b1, 0, 1'b0);
        run_req(4'b0000, 1'b1, 5, 1'b0);
        run_reject(4'b1001, 3);
        run_restore();

        void'($urandom(32'd20240611));
        for (int i = 0; i < 30; i++) begin
            logic [3:0] m = 4'($urandom % 16);
            int s = int'($urandom % 8);
            logic d = 1'($urandom % 2);
            if ((m & DIV) != 4'h0)
                run_reject(m, s);
            else
                run_req(m, d, s, (s != 0 && m != 0) && ($urandom % 2 == 1));
        end

        // R1: lock lost later.
        gen_lock = 1'b0;
        req_valid = 1'b1; req_mask = 4'b0100; req_steps = 3'd2;
        expect_idle("R1", 3);
        summary();
    end
endmodule